// File: doc/BRIEF.md
# ADC Conversion Sequencer with Selection Latch

This block paces the conversion cycles of an analog-to-digital converter. It also decides when the analog channel and reference selection reach the converter. Software writes a selection register that holds a channel field and a reference field. A working copy of that register drives the analog multiplexer and the reference switch. The copy follows the register whenever no conversion is running. It freezes once a conversion begins, so that the sampling window sees a steady input. It opens again during the final converter clock cycle of the conversion.

Conversions advance on a converter clock enable (`adc_ce`) and last a fixed number of enabled clocks. A conversion can start in three ways: a software start, an automatic restart in free-running mode, or a rising edge on the trigger input in auto-trigger mode. At the end of each conversion the block sets a completion flag. It raises an interrupt request while that flag and the interrupt enable are both set. Clearing the converter enable stops any conversion at once.

Top module: `adc_seq_latch`

## Requirements
- R1: After reset, `mux_sel`, `ref_sel`, `busy`, `done_flag` and `irq` are all 0.
- R2: A write with `cpu_addr`=0 stores the selection register. The channel sits in bits [MUX_W-1:0] and the reference in bits [MUX_W+REF_W-1:MUX_W]. While no conversion is running, `mux_sel` and `ref_sel` show the stored value one clock after the write edge.
- R3: From the edge that starts a conversion until its last converter clock cycle begins, `mux_sel` and `ref_sel` hold their value, whatever is written to the selection register.
- R4: In the last converter clock cycle of a conversion, the outputs take the stored selection again, and not earlier. The completion flag sets at the enabled edge that closes that cycle.
- R5: A write with `cpu_addr`=1 is a control write. Its bits are: 0 = enable, 1 = start, 2 = auto-trigger, 3 = free-running, 4 = flag clear, 5 = interrupt enable. A control write with both bit 0 and bit 1 set raises `busy` from the write edge. The conversion begins on the first clock after that edge on which `adc_ce` is high.
- R6: A conversion ends at its CONV_CYCLES-th enabled edge. Outside free-running mode, `busy` then clears and `done_flag` sets, so with `adc_ce` held high `busy` stays high for CONV_CYCLES+1 clocks.
- R7: A control write with bit 4 set clears `done_flag`. `irq` is high exactly while `done_flag` and interrupt enable (bit 5) are both set.
- R8: In free-running mode (bit 3), the next conversion starts at the completing edge and `busy` stays high. A selection written after a completion therefore reaches the outputs only at the end of the following conversion.
- R9: In auto-trigger mode (bits 0 and 2 set), a rising edge on `trig_in` seen while idle starts a conversion in the same way as a start write. Edges that arrive while `busy` is high are ignored, and so are edges seen while bit 0 or bit 2 is clear.
- R10: A control write with bit 0 clear drops `busy` at its edge and ends any running conversion without setting the flag. The outputs then track the selection register again.
- R11: A start request (bit 1) in a control write whose bit 0 is clear does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_ce | input | 1 | Converter clock enable; one pulse per converter clock |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 = selection register, 1 = control register |
| cpu_wdata | input | DATA_W | Write data |
| trig_in | input | 1 | Trigger source for auto-trigger mode |
| mux_sel | output | MUX_W | Channel select to the analog multiplexer |
| ref_sel | output | REF_W | Reference select to the analog front end |
| busy | output | 1 | Start bit read value; high from the request until completion |
| done_flag | output | 1 | Conversion-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The timing of each result is fixed relative to its stimulus:
- The selection outputs move one clock after a selection write while the latch is open.
- `busy` rises at the edge of a start write or a trigger edge.
- The conversion begins at the next clock on which `adc_ce` is high.
- `done_flag` and the fall of `busy` come CONV_CYCLES enabled edges after that.
- `irq` follows the flag in the same clock.

A behavioural model in the bench advances at each rising edge using the same input values the design sees. The bench compares every output with the model at each falling edge, after all registers have settled. Directed checks wait on these events and sample in the clocks just named, for example the last busy clock before completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Control register bit positions
    localparam int CTL_EN   = 0;
    localparam int CTL_GO   = 1;
    localparam int CTL_AUTO = 2;
    localparam int CTL_FREE = 3;
    localparam int CTL_CLR  = 4;
    localparam int CTL_IE   = 5;

    // Register addresses
    localparam logic ADDR_SEL  = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic auto_trig;
        logic free_run;
        logic irq_en;
    } ctrl_cfg_t;

    function automatic int cnt_width(input int cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              done_pulse,
    output logic [SEL_W-1:0]  cpu_sel,
    output ctrl_cfg_t         cfg,
    output logic              start_req,
    output logic              abort_req,
    output logic              flag
);

    logic sel_wr;
    logic ctl_wr;

    assign sel_wr    = cpu_wr && (cpu_addr == ADDR_SEL);
    assign ctl_wr    = cpu_wr && (cpu_addr == ADDR_CTRL);
    assign start_req = ctl_wr && cpu_wdata[CTL_EN] && cpu_wdata[CTL_GO];
    assign abort_req = ctl_wr && !cpu_wdata[CTL_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_sel <= '0;
        end else if (sel_wr) begin
            cpu_sel <= cpu_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (ctl_wr) begin
            cfg.en        <= cpu_wdata[CTL_EN];
            cfg.auto_trig <= cpu_wdata[CTL_AUTO];
            cfg.free_run  <= cpu_wdata[CTL_FREE];
            cfg.irq_en    <= cpu_wdata[CTL_IE];
        end
    end

    // Completion has priority over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (done_pulse) begin
            flag <= 1'b1;
        end else if (ctl_wr && cpu_wdata[CTL_CLR]) begin
            flag <= 1'b0;
        end
    end

    logic wdata_unused;
    assign wdata_unused = ^cpu_wdata;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 13
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      adc_ce,
    input  logic      trig_in,
    input  ctrl_cfg_t cfg,
    input  logic      start_req,
    input  logic      abort_req,
    output logic      busy,
    output logic      sel_open,
    output logic      done_pulse
);

    localparam int CNT_W = cnt_width(CONV_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             trig_q;
    logic             trig_rise;
    logic             arm;
    logic             at_last;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign trig_rise = trig_in && !trig_q;
    assign arm       = (state == ST_IDLE) &&
                       (start_req || (trig_rise && cfg.auto_trig && cfg.en));
    assign at_last   = (state == ST_CONV) && (cnt == LAST);
    assign done_pulse = at_last && adc_ce && !abort_req;

    always_ff @(posedge clk) begin
        if (rst || abort_req) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (arm) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (adc_ce) begin
                        state <= ST_CONV;
                        cnt   <= '0;
                    end
                end
                ST_CONV: begin
                    if (adc_ce) begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (!cfg.free_run) state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign sel_open = (state != ST_CONV) || at_last;

endmodule

// File: rtl/adc_seq_shadow.sv
module adc_seq_shadow #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_open,
    input  logic [SEL_W-1:0] cpu_sel,
    output logic [SEL_W-1:0] work_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            work_sel <= '0;
        end else if (sel_open) begin
            work_sel <= cpu_sel;
        end
    end

endmodule

// File: rtl/adc_seq_latch.sv
module adc_seq_latch
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int MUX_W       = 2,
    parameter int REF_W       = 1,
    parameter int CONV_CYCLES = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_ce,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              trig_in,
    output logic [MUX_W-1:0]  mux_sel,
    output logic [REF_W-1:0]  ref_sel,
    output logic              busy,
    output logic              done_flag,
    output logic              irq
);

    localparam int SEL_W = MUX_W + REF_W;

    logic [SEL_W-1:0] cpu_sel_w;
    logic [SEL_W-1:0] work_sel_w;
    ctrl_cfg_t        cfg_w;
    logic             start_req_w;
    logic             abort_req_w;
    logic             done_pulse_w;
    logic             sel_open_w;

    adc_seq_regs #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .done_pulse (done_pulse_w),
        .cpu_sel    (cpu_sel_w),
        .cfg        (cfg_w),
        .start_req  (start_req_w),
        .abort_req  (abort_req_w),
        .flag       (done_flag)
    );

    adc_seq_ctrl #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .adc_ce     (adc_ce),
        .trig_in    (trig_in),
        .cfg        (cfg_w),
        .start_req  (start_req_w),
        .abort_req  (abort_req_w),
        .busy       (busy),
        .sel_open   (sel_open_w),
        .done_pulse (done_pulse_w)
    );

    adc_seq_shadow #(
        .SEL_W (SEL_W)
    ) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .sel_open (sel_open_w),
        .cpu_sel  (cpu_sel_w),
        .work_sel (work_sel_w)
    );

    assign mux_sel = work_sel_w[MUX_W-1:0];
    assign ref_sel = work_sel_w[SEL_W-1:MUX_W];
    assign irq     = done_flag && cfg_w.irq_en;

endmodule

// File: rtl/adc_seq_latch_chk.sv
module adc_seq_latch_chk #(
    parameter int DATA_W = 8,
    parameter int MUX_W  = 2,
    parameter int REF_W  = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     adc_ce,
    input logic                     cpu_wr,
    input logic                     cpu_addr,
    input logic [DATA_W-1:0]        cpu_wdata,
    input logic [MUX_W-1:0]         mux_sel,
    input logic [REF_W-1:0]         ref_sel,
    input logic                     busy,
    input logic                     done_flag,
    input logic                     irq,
    input logic                     sel_open,
    input logic                     done_pulse,
    input logic [MUX_W+REF_W-1:0]   cpu_sel
);

    logic ctl_off_wr;
    assign ctl_off_wr = cpu_wr && cpu_addr && !cpu_wdata[0];

    logic wdata_unused;
    assign wdata_unused = ^cpu_wdata;

    // R2: an open latch copies the stored selection at the next edge
    p_track_r2: assert property (@(posedge clk) disable iff (rst)
        sel_open |=> ({ref_sel, mux_sel} == $past(cpu_sel)));

    // R3: a closed latch keeps the outputs unchanged
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sel_open |=> $stable({ref_sel, mux_sel}));

    // R5: the latch only closes on an enabled converter clock
    p_start_ce_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_open) |-> $past(adc_ce));

    // R6: completion leaves the flag set
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> done_flag);

    // R7: no request without the flag
    p_irq_flag_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> done_flag);

    // R10: clearing the enable ends all activity
    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_off_wr |=> !busy);

endmodule

bind adc_seq_latch adc_seq_latch_chk #(
    .DATA_W (DATA_W),
    .MUX_W  (MUX_W),
    .REF_W  (REF_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adc_ce     (adc_ce),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .mux_sel    (mux_sel),
    .ref_sel    (ref_sel),
    .busy       (busy),
    .done_flag  (done_flag),
    .irq        (irq),
    .sel_open   (sel_open_w),
    .done_pulse (done_pulse_w),
    .cpu_sel    (cpu_sel_w)
);

// File: tb/adc_seq_latch_bench.sv
module adc_seq_latch_bench;

    localparam int N = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_ce = 1'b1;
    logic       cpu_wr = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic       trig_in = 1'b0;
    logic [1:0] mux_sel;
    logic [0:0] ref_sel;
    logic       busy;
    logic       done_flag;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int ce_mode = 0;
    int ce_cnt = 0;

    always #4 clk = ~clk;

    adc_seq_latch #(
        .DATA_W (8), .MUX_W (2), .REF_W (1), .CONV_CYCLES (N)
    ) u_adc_seq_latch (
        .clk (clk), .rst (rst), .adc_ce (adc_ce), .cpu_wr (cpu_wr),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .trig_in (trig_in),
        .mux_sel (mux_sel), .ref_sel (ref_sel), .busy (busy),
        .done_flag (done_flag), .irq (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int  m_cpu, m_work, m_state, m_elapsed;
    bit  m_en, m_auto, m_free, m_ie, m_flag, m_trig_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_cpu = 0; m_work = 0; m_state = 0; m_elapsed = 0;
            m_en = 0; m_auto = 0; m_free = 0; m_ie = 0; m_flag = 0; m_trig_prev = 0;
        end else begin
            automatic bit wsel = cpu_wr && !cpu_addr;
            automatic bit wctl = cpu_wr && cpu_addr;
            automatic bit kill = wctl && !cpu_wdata[0];
            automatic bit rise = trig_in && !m_trig_prev;
            automatic bit open = (m_state != 2) || (m_elapsed == N - 1);
            automatic bit fin  = (m_state == 2) && adc_ce && (m_elapsed == N - 1);
            if (open) m_work = m_cpu;
            if (fin && !kill) m_flag = 1;
            else if (wctl && cpu_wdata[4]) m_flag = 0;
            if (kill) begin
                m_state = 0; m_elapsed = 0;
            end else if (m_state == 0) begin
                if ((wctl && cpu_wdata[0] && cpu_wdata[1]) || (rise && m_auto && m_en))
                    m_state = 1;
            end else if (m_state == 1) begin
                if (adc_ce) begin m_state = 2; m_elapsed = 0; end
            end else if (adc_ce) begin
                if (m_elapsed == N - 1) begin
                    m_elapsed = 0;
                    if (!m_free) m_state = 0;
                end else begin
                    m_elapsed++;
                end
            end
            if (wsel) m_cpu = int'(cpu_wdata[2:0]);
            if (wctl) begin
                m_en = cpu_wdata[0]; m_auto = cpu_wdata[2];
                m_free = cpu_wdata[3]; m_ie = cpu_wdata[5];
            end
            m_trig_prev = trig_in;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 selection vs model", int'({ref_sel, mux_sel}), m_work);
            check("R5 busy vs model", int'(busy), int'(m_state != 0));
            check("R6 flag vs model", int'(done_flag), int'(m_flag));
            check("R7 irq vs model", int'(irq), int'(m_flag && m_ie));
        end
    end

    always @(negedge clk) begin
        ce_cnt++;
        adc_ce <= (ce_mode == 0) ? 1'b1 : (ce_cnt % 3 == 0);
    end

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wait_flag();
        while (!done_flag) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        int last_mux;
        bit held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mux", int'(mux_sel), 0);
        check("R1 ref", int'(ref_sel), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 flag", int'(done_flag), 0);
        check("R1 irq", int'(irq), 0);

        // R2 tracking while idle
        wr(1'b0, 8'h05);
        @(negedge clk);
        check("R2 mux follows", int'(mux_sel), 1);
        check("R2 ref follows", int'(ref_sel), 1);

        // R3 and R4: lock during single conversion
        wr(1'b1, 8'h03);
        check("R5 busy after start", int'(busy), 1);
        wr(1'b0, 8'h02);
        repeat (5) begin
            check("R3 mux held", int'(mux_sel), 1);
            @(negedge clk);
        end
        last_mux = int'(mux_sel);
        while (busy) begin last_mux = int'(mux_sel); @(negedge clk); end
        check("R4 not reopened early", last_mux, 1);
        check("R4 mux after", int'(mux_sel), 2);
        check("R4 ref after", int'(ref_sel), 0);
        check("R6 flag set", int'(done_flag), 1);

        // R7 clear
        wr(1'b1, 8'h11);
        check("R7 flag cleared", int'(done_flag), 0);

        // R5 and R6 busy length
        wr(1'b1, 8'h03);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        check("R6 busy length", cnt, N + 1);

        // R7 irq
        wr(1'b1, 8'h23);
        wait_idle();
        check("R7 irq raised", int'(irq), 1);
        wr(1'b1, 8'h30);
        check("R7 irq dropped", int'(irq), 0);

        // R8 free running
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h0B);
        wait_flag();
        wr(1'b1, 8'h19);
        wr(1'b0, 8'h03);
        check("R8 still busy", int'(busy), 1);
        held = 1;
        while (!done_flag) begin
            if (mux_sel != 2'd1) held = 0;
            @(negedge clk);
        end
        check("R8 old channel kept", int'(held), 1);
        check("R8 new channel later", int'(mux_sel), 3);

        // R10 abort
        wr(1'b1, 8'h08);
        check("R10 busy dropped", int'(busy), 0);
        wr(1'b0, 8'h06);
        @(negedge clk);
        check("R10 tracking again", int'({ref_sel, mux_sel}), 6);

        // R9 auto trigger
        wr(1'b1, 8'h15);
        pulse_trig();
        check("R9 trigger starts", int'(busy), 1);
        repeat (4) @(negedge clk);
        pulse_trig();
        wait_idle();
        check("R9 flag after trigger", int'(done_flag), 1);
        repeat (3) @(negedge clk);
        check("R9 retrigger ignored", int'(busy), 0);
        wr(1'b1, 8'h11);
        pulse_trig();
        repeat (2) @(negedge clk);
        check("R9 no auto no start", int'(busy), 0);

        // R11 start without enable
        wr(1'b1, 8'h02);
        repeat (3) @(negedge clk);
        check("R11 start ignored", int'(busy), 0);

        // slow converter clock, free running, checked against model
        ce_mode = 1;
        wr(1'b0, 8'h04);
        wr(1'b1, 8'h0B);
        wait_flag();
        wr(1'b1, 8'h19);
        wr(1'b0, 8'h01);
        wait_flag();
        wr(1'b1, 8'h10);
        check("R10 abort slow", int'(busy), 0);
        repeat (6) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule